// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash device. After system logic has written a program or erase command sequence, it pulses `start`. The poller then reads the device status byte repeatedly, always at one address. It decides whether the embedded operation has ended by checking whether a chosen status bit changes between two reads made back to back. The outcome goes to the system as a one-cycle `done` pulse, with either `pass` or `fail` high in the same cycle.

While the watched bit keeps changing, the poller also looks at the time-limit flag. This is status bit 5. When that flag is high, the poller makes one more pair of reads before it decides. The extra pair covers the case where the operation ended at the same moment the flag rose. If the bit still changes on that second look, the poller writes the reset command to the device and then reports failure. A parameterised limit on the number of polling pairs stops the polling if neither completion nor the flag ever appears. The bus toward the device is a request/acknowledge master. Each transfer holds its request until the device acknowledges it.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: During reset and after it, `bus_req`, `done`, `pass` and `fail` are low, and no bus transfer is started until `start` is seen.
- R2: Every poll transfer is a read (`bus_we` low) at the `poll_addr` captured with `start`. `bus_req` stays high with stable `bus_we`, `bus_addr` and `bus_wdata` until `bus_ack`, and it is low in the cycle after an acknowledge.
- R3: When the watched bit is equal in both reads of a pair, the poller pulses `done` with `pass` and makes no write.
- R4: When the watched bit differs within a pair and status bit 5 of the second read is low, the poller starts another read pair.
- R5: When the watched bit differs and bit 5 of the second read is high, a fresh read pair is made. If the watched bit is equal in that pair, the result is `pass`.
- R6: When the watched bit still differs in that fresh pair, exactly one write of data 0xF0 to `poll_addr` is made, and `done` with `fail` follows it.
- R7: `tog_sel` is captured at `start`. 0 watches status bit 6 and 1 watches status bit 2. The other toggle bit, and bit 0, have no effect on the result.
- R8: After `MAX_PAIRS` (default 16) pairs that change with bit 5 low, the poller writes 0xF0 and reports `fail`, so it makes `2*MAX_PAIRS` reads.
- R9: `done` lasts one cycle, with exactly one of `pass`/`fail` high and neither high without it. A `start` seen while polling is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| start | input | 1 | Begin polling (accepted only when idle) |
| tog_sel | input | 1 | Watched bit: 0 = status bit 6, 1 = status bit 2 |
| poll_addr | input | ADDR_W | Address used for status reads and the reset write |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation finished successfully (with done) |
| fail | output | 1 | Operation failed, reset command issued (with done) |
| bus_req | output | 1 | Transfer request toward the device |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Transfer address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |
| bus_ack | input | 1 | Transfer acknowledge |

## Verification
A scripted device model returns status bytes from several patterns:
- one already settled;
- one that stops toggling after some reads with the limit flag never set;
- one that sets the flag while it keeps toggling;
- one that sets the flag just before toggling ends;
- one that never settles.

Together these separate the plain pass path, the fresh-pair recheck that passes, the recheck that fails, and the pair-limit failure. For each pattern, the total number of reads tells the paths apart.

Patterns where only the unwatched toggle bit, or bit 0, changes show that the selection works. `tog_sel` is flipped after `start` to show that it is captured at `start`. Directed cases cover reset in the middle of an operation and a second `start` while polling.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD_A  = 3'd1,
        ST_RD_B  = 3'd2,
        ST_CK_A  = 3'd3,
        ST_CK_B  = 3'd4,
        ST_WR    = 3'd5
    } tpoll_state_e;

    localparam int unsigned TPOLL_STATUS_W = 8;

endpackage

// File: rtl/tpoll_bus.sv
// One request/acknowledge transfer at a time; read data captured into a register.
module tpoll_bus #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              issue_we,
    input  logic [DATA_W-1:0] issue_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              cyc_done
);

    typedef struct packed {
        logic              req;
        logic              we;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] rd;
        logic              fin;
    } bus_reg_t;

    bus_reg_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.fin = 1'b0;
        if (r_q.req) begin
            if (bus_ack) begin
                r_d.req = 1'b0;
                r_d.fin = 1'b1;
                if (!r_q.we) begin
                    r_d.rd = bus_rdata;
                end
            end
        end else if (issue) begin
            r_d.req = 1'b1;
            r_d.we  = issue_we;
            r_d.wd  = issue_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_req   = r_q.req;
    assign bus_we    = r_q.we;
    assign bus_wdata = r_q.wd;
    assign rd_data   = r_q.rd;
    assign cyc_done  = r_q.fin;

endmodule

// File: rtl/tpoll_bitsel.sv
// Picks the watched toggle bit and the time-limit flag from a status byte.
module tpoll_bitsel #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned TOG_BIT     = 6,
    parameter int unsigned ALT_TOG_BIT = 2,
    parameter int unsigned TMO_BIT     = 5
) (
    input  logic [DATA_W-1:0] status,
    input  logic              use_alt,
    output logic              tog,
    output logic              tmo
);

    generate
        if (TOG_BIT == ALT_TOG_BIT) begin : g_single
            logic unused_sel;
            assign unused_sel = use_alt;
            assign tog = status[TOG_BIT];
        end else begin : g_mux
            assign tog = use_alt ? status[ALT_TOG_BIT] : status[TOG_BIT];
        end
    endgenerate

    assign tmo = status[TMO_BIT];

endmodule

// File: rtl/tpoll_pair_cnt.sv
// Counts read pairs that changed with the time-limit flag low.
module tpoll_pair_cnt #(
    parameter int unsigned MAX_PAIRS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int unsigned CNT_W = $clog2(MAX_PAIRS + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && !last) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == CNT_W'(MAX_PAIRS - 1));

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
    import tpoll_pkg::*;
#(
    parameter int unsigned          DATA_W      = TPOLL_STATUS_W,
    parameter int unsigned          ADDR_W      = 20,
    parameter int unsigned          MAX_PAIRS   = 16,
    parameter int unsigned          TOG_BIT     = 6,
    parameter int unsigned          ALT_TOG_BIT = 2,
    parameter int unsigned          TMO_BIT     = 5,
    parameter logic [DATA_W-1:0]    RST_CMD     = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tog_sel,
    input  logic [ADDR_W-1:0] poll_addr,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack
);

    typedef struct packed {
        tpoll_state_e      st;
        logic              pend;
        logic              first;
        logic              sel;
        logic [ADDR_W-1:0] addr;
        logic              done;
        logic              pass;
        logic              fail;
    } ctl_t;

    ctl_t c_q, c_d;

    logic              issue;
    logic              issue_we;
    logic [DATA_W-1:0] issue_wdata;
    logic [DATA_W-1:0] rd_data;
    logic              cyc_done;
    logic              tog_bit;
    logic              tmo_bit;
    logic              cnt_clr;
    logic              cnt_inc;
    logic              cnt_last;

    tpoll_bus #(.DATA_W(DATA_W)) i_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (issue),
        .issue_we    (issue_we),
        .issue_wdata (issue_wdata),
        .bus_ack     (bus_ack),
        .bus_rdata   (bus_rdata),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .rd_data     (rd_data),
        .cyc_done    (cyc_done)
    );

    tpoll_bitsel #(
        .DATA_W      (DATA_W),
        .TOG_BIT     (TOG_BIT),
        .ALT_TOG_BIT (ALT_TOG_BIT),
        .TMO_BIT     (TMO_BIT)
    ) i_bitsel (
        .status  (rd_data),
        .use_alt (c_q.sel),
        .tog     (tog_bit),
        .tmo     (tmo_bit)
    );

    tpoll_pair_cnt #(.MAX_PAIRS(MAX_PAIRS)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .last  (cnt_last)
    );

    always_comb begin
        c_d         = c_q;
        c_d.done    = 1'b0;
        c_d.pass    = 1'b0;
        c_d.fail    = 1'b0;
        issue       = 1'b0;
        issue_we    = 1'b0;
        issue_wdata = '0;
        cnt_clr     = 1'b0;
        cnt_inc     = 1'b0;

        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st   = ST_RD_A;
                    c_d.sel  = tog_sel;
                    c_d.addr = poll_addr;
                    c_d.pend = 1'b0;
                    cnt_clr  = 1'b1;
                end
            end
            ST_RD_A, ST_CK_A: begin
                if (!c_q.pend) begin
                    issue    = 1'b1;
                    c_d.pend = 1'b1;
                end else if (cyc_done) begin
                    c_d.pend  = 1'b0;
                    c_d.first = tog_bit;
                    c_d.st    = (c_q.st == ST_RD_A) ? ST_RD_B : ST_CK_B;
                end
            end
            ST_RD_B: begin
                if (!c_q.pend) begin
                    issue    = 1'b1;
                    c_d.pend = 1'b1;
                end else if (cyc_done) begin
                    c_d.pend = 1'b0;
                    if (tog_bit == c_q.first) begin
                        c_d.st   = ST_IDLE;
                        c_d.done = 1'b1;
                        c_d.pass = 1'b1;
                    end else if (tmo_bit) begin
                        c_d.st = ST_CK_A;
                    end else if (cnt_last) begin
                        c_d.st = ST_WR;
                    end else begin
                        cnt_inc = 1'b1;
                        c_d.st  = ST_RD_A;
                    end
                end
            end
            ST_CK_B: begin
                if (!c_q.pend) begin
                    issue    = 1'b1;
                    c_d.pend = 1'b1;
                end else if (cyc_done) begin
                    c_d.pend = 1'b0;
                    if (tog_bit == c_q.first) begin
                        c_d.st   = ST_IDLE;
                        c_d.done = 1'b1;
                        c_d.pass = 1'b1;
                    end else begin
                        c_d.st = ST_WR;
                    end
                end
            end
            ST_WR: begin
                if (!c_q.pend) begin
                    issue       = 1'b1;
                    issue_we    = 1'b1;
                    issue_wdata = RST_CMD;
                    c_d.pend    = 1'b1;
                end else if (cyc_done) begin
                    c_d.pend = 1'b0;
                    c_d.st   = ST_IDLE;
                    c_d.done = 1'b1;
                    c_d.fail = 1'b1;
                end
            end
            default: begin
                c_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign done     = c_q.done;
    assign pass     = c_q.pass;
    assign fail     = c_q.fail;
    assign bus_addr = c_q.addr;

endmodule

// File: rtl/tpoll_chk.sv
module tpoll_chk #(
    parameter int unsigned       DATA_W  = 8,
    parameter int unsigned       ADDR_W  = 20,
    parameter logic [DATA_W-1:0] RST_CMD = 8'hF0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack
);

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

    assert_req_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> !bus_req);

    assert_rst_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> (bus_wdata == RST_CMD));

    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass ^ fail));

    assert_flag_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pass || fail) |-> done);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_quiet_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);

endmodule

bind toggle_poll_ctrl tpoll_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .RST_CMD (RST_CMD)
) i_tpoll_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .pass      (pass),
    .fail      (fail),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack)
);

// File: tb/test_toggle_poll_ctrl.sv
module test_toggle_poll_ctrl;

    localparam int DW = 8;
    localparam int AW = 20;

    typedef struct packed {
        logic       which;     // 0: bit 6 toggles, 1: bit 2 toggles
        logic [7:0] stop;      // first read index after which the bit stays put
        logic [7:0] q5_at;     // first read index with bit 5 high
        logic       sel;       // tog_sel given with start
        logic       exp_pass;
        logic [7:0] exp_reads;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd0,   8'd255, 1'b0, 1'b1, 8'd2},   // R3 settled
        '{1'b0, 8'd5,   8'd255, 1'b0, 1'b1, 8'd8},   // R4 pairs then pass
        '{1'b0, 8'd100, 8'd3,   1'b0, 1'b0, 8'd6},   // R6 recheck fails
        '{1'b0, 8'd4,   8'd3,   1'b0, 1'b1, 8'd6},   // R5 race recheck passes
        '{1'b0, 8'd200, 8'd255, 1'b0, 1'b0, 8'd32},  // R8 pair limit
        '{1'b1, 8'd100, 8'd255, 1'b0, 1'b1, 8'd2},   // R7 bit2 ignored
        '{1'b1, 8'd5,   8'd255, 1'b1, 1'b1, 8'd8},   // R7 bit2 watched
        '{1'b0, 8'd100, 8'd255, 1'b1, 1'b1, 8'd2},   // R7 bit6 ignored
        '{1'b0, 8'd0,   8'd0,   1'b0, 1'b1, 8'd2}    // R3 flag high, settled
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          tog_sel = 1'b0;
    logic [AW-1:0] poll_addr = '0;
    logic          done, pass, fail;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ack = 1'b0;

    int   checks = 0;
    int   errors = 0;
    vec_t cur;
    logic [AW-1:0] cur_addr = '0;
    int   rd_cnt = 0;
    int   wr_cnt = 0;
    int   addr_err = 0;
    logic [DW-1:0] wr_data = '0;

    always #2.5 clk = ~clk;

    toggle_poll_ctrl i_toggle_poll_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tog_sel   (tog_sel),
        .poll_addr (poll_addr),
        .done      (done),
        .pass      (pass),
        .fail      (fail),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack)
    );

    function automatic logic [7:0] status_byte(int i);
        logic [7:0] b;
        int         t;
        t    = (i < int'(cur.stop)) ? i : int'(cur.stop);
        b    = 8'h00;
        b[0] = i[0];
        if (cur.which) b[2] = t[0];
        else           b[6] = t[0];
        b[5] = (i >= int'(cur.q5_at));
        return b;
    endfunction

    // Device model, driven away from the active edge.
    always @(negedge clk) begin
        if (bus_req && !bus_ack) begin
            bus_ack = 1'b1;
            if (bus_addr != cur_addr) addr_err = addr_err + 1;
            if (bus_we) begin
                wr_cnt  = wr_cnt + 1;
                wr_data = bus_wdata;
            end else begin
                bus_rdata = status_byte(rd_cnt);
                rd_cnt    = rd_cnt + 1;
            end
        end else begin
            bus_ack = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input logic [AW-1:0] a, input bit extra_start);
        bit got;
        int n;
        int dones;
        logic p, f;
        cur      = v;
        cur_addr = a;
        rd_cnt   = 0;
        wr_cnt   = 0;
        addr_err = 0;
        wr_data  = '0;
        @(negedge clk);
        poll_addr = a;
        tog_sel   = v.sel;
        start     = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        tog_sel = ~v.sel;               // R7: must have been captured already
        poll_addr = ~a;
        got = 1'b0; n = 0; dones = 0; p = 1'b0; f = 1'b0;
        while (!got && n < 3000) begin
            @(negedge clk);
            start = (extra_start && n == 6);
            if (done) begin
                got = 1'b1; p = pass; f = fail; dones = dones + 1;
            end
            n = n + 1;
        end
        start = 1'b0;
        chk(got, "R9 done seen (timeout)", int'(got), 1);
        chk(p == v.exp_pass && f == !v.exp_pass, "R3/R5/R6/R8 outcome pass", int'(p), int'(v.exp_pass));
        chk(rd_cnt == int'(v.exp_reads), "R4/R5/R8 read count", rd_cnt, int'(v.exp_reads));
        chk(wr_cnt == (v.exp_pass ? 0 : 1), "R6 write count", wr_cnt, v.exp_pass ? 0 : 1);
        if (!v.exp_pass)
            chk(wr_data == 8'hF0, "R6 reset data", int'(wr_data), 'hF0);
        chk(addr_err == 0, "R2 address", addr_err, 0);
        @(negedge clk);
        chk(!done && !pass && !fail, "R9 done one cycle", int'(done), 0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (done) dones = dones + 1;
            if (bus_req) addr_err = addr_err + 1;
        end
        chk(dones == 1 && addr_err == 0, "R9 single done, idle after", dones, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: actual expired expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        start = 1'b1;                   // R1: start during reset has no effect
        repeat (4) @(negedge clk);
        chk(!bus_req && !done && !pass && !fail, "R1 reset outputs", int'(bus_req), 0);
        start = 1'b0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!bus_req && !done, "R1 idle after reset", int'(bus_req), 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], AW'(20'h01111 * (i + 1)), 1'b0);
        end

        // R9: a second start while polling is ignored
        run_vec(VECS[1], 20'hABCDE, 1'b1);

        // R1: reset in the middle of a long poll
        cur = VECS[4]; cur_addr = 20'h00042; rd_cnt = 0;
        @(negedge clk);
        poll_addr = 20'h00042; tog_sel = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!bus_req && !done && !fail, "R1 mid-op reset", int'(bus_req), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!bus_req, "R1 no transfer without start", int'(bus_req), 0);
        run_vec(VECS[3], 20'h00777, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule